// File: doc/BRIEF.md
# Host-Interface Power State Controller

This block is the device-side controller for the operating state of a host-facing interface. It starts in a reset state after power-on and reports a ready state once the device's internal initialization finishes. From ready, the host moves it into the active level M0. From M0 the host can lower it into one of three suspend levels: M1 (device suspended), M2 (low power, where the device may drop further) and M3 (both sides suspended, link unreachable). Host register access is blocked in reset. Data transfers are allowed only in M0.

All inputs are plain control pins sampled on the rising clock edge. There is no data stream, so the block has no valid/ready handshake. A host request is a one-cycle strobe that carries a 3-bit target code. Every state change appears on the outputs one cycle after the edge that sampled its cause. A link-suspend indication drops any link-reachable level straight to M3. A host request for reset is obeyed from any state. A rejected request sets a sticky error bit, which only a reset request clears.

Top module: `hif_pwr_ctrl`

## Requirements
- R1: After power-on reset the state code is 0 (reset), host register access and data transfer enables are low, and the error bit is low.
- R2: In reset, with the initialization-done input high and not blocked, the state code becomes 1 (ready) one cycle later. With that input low the state stays 0.
- R3: Host register access enable is high in every state except reset (code 0).
- R4: A request with code 2 (M0) is honored from ready (1), M1 (3), M2 (4) and M3 (5) with the link up. Data transfer enable is high only while the code is 2.
- R5: A request for M0 while in reset or already in M0 leaves the state unchanged and sets the error bit, which stays set until a reset request.
- R6: A request for M1 (3) is honored only from M0. A request for M2 (4) is honored only from M0 or M1. A request for M3 (5) is honored only from M0, M1 or M2. Codes 1, 6 and 7 are never honored. Every rejected request sets the error bit and leaves the state unchanged.
- R7: A request with code 0 forces the reset state from any state and clears the error bit. After it, ready is not entered again until initialization-done has been seen low.
- R8: Link-suspend high while in M0, M1 or M2 moves the block to M3 in one cycle. A concurrent non-reset request is dropped without setting the error bit.
- R9: In M3 with link-suspend high, an M0 request is rejected and sets the error bit.
- R10: A reset request in the same cycle as link-suspend wins: the next state is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| init_done | input | 1 | Device internal initialization complete |
| req_valid | input | 1 | One-cycle host state request strobe |
| req_code | input | 3 | Requested target state code |
| link_suspend | input | 1 | Link no longer reachable by the device |
| state_code | output | 3 | Current state code (0 reset, 1 ready, 2 M0, 3 M1, 4 M2, 5 M3) |
| reg_access_en | output | 1 | Host register access allowed |
| xfer_en | output | 1 | Data transfers allowed |
| req_err | output | 1 | Sticky flag for a rejected request |

## Verification
The two functions that can fall in the same cycle are the host request path and the link-suspend path. The bench raises link-suspend in the same cycle as a downward request (M1) and as a reset request. It then checks that the downward request is dropped with the error bit still clear, and that the reset request wins. It also issues an M0 request while in M3 with link-suspend held, and judges the state code and error bit one cycle later.

// File: rtl/hif_pwr_pkg.sv
package hif_pwr_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RESET = 3'd0,
    ST_READY = 3'd1,
    ST_M0    = 3'd2,
    ST_M1    = 3'd3,
    ST_M2    = 3'd4,
    ST_M3    = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/hif_req_decode.sv
module hif_req_decode
  import hif_pwr_pkg::*;
(
  input  pwr_state_e      cur_st,
  input  logic            req_valid,
  input  logic [ST_W-1:0] req_code,
  input  logic            link_suspend,
  input  logic            init_ok,
  output pwr_state_e      nxt_st,
  output logic            err_set,
  output logic            err_clr
);
  logic rst_req;
  logic link_up_lvl;
  logic legal;

  assign rst_req     = req_valid && (req_code == ST_RESET);
  assign link_up_lvl = (cur_st == ST_M0) || (cur_st == ST_M1) || (cur_st == ST_M2);

  always_comb begin
    legal = 1'b0;
    unique case (req_code)
      ST_M0:   legal = ((cur_st == ST_READY) || (cur_st == ST_M1) || (cur_st == ST_M2) ||
                        (cur_st == ST_M3)) && !link_suspend;
      ST_M1:   legal = (cur_st == ST_M0);
      ST_M2:   legal = (cur_st == ST_M0) || (cur_st == ST_M1);
      ST_M3:   legal = link_up_lvl;
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    nxt_st  = cur_st;
    err_set = 1'b0;
    err_clr = 1'b0;
    if (rst_req) begin
      nxt_st  = ST_RESET;
      err_clr = 1'b1;
    end else if (link_suspend && link_up_lvl) begin
      nxt_st = ST_M3;
    end else begin
      if (req_valid) begin
        if (legal) nxt_st = pwr_state_e'(req_code);
        else       err_set = 1'b1;
      end
      if (cur_st == ST_RESET && init_ok) nxt_st = ST_READY;
    end
  end
endmodule

// File: rtl/hif_state_reg.sv
module hif_state_reg
  import hif_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_done,
  input  logic            req_valid,
  input  logic [ST_W-1:0] req_code,
  input  logic            link_suspend,
  output pwr_state_e      state,
  output logic            err
);
  pwr_state_e nxt_st;
  logic       err_set;
  logic       err_clr;
  logic       init_blk;
  logic       init_ok;
  logic       rst_req;

  assign rst_req = req_valid && (req_code == ST_RESET);
  assign init_ok = init_done && !init_blk;

  hif_req_decode u_dec (
    .cur_st       (state),
    .req_valid    (req_valid),
    .req_code     (req_code),
    .link_suspend (link_suspend),
    .init_ok      (init_ok),
    .nxt_st       (nxt_st),
    .err_set      (err_set),
    .err_clr      (err_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RESET;
      err      <= 1'b0;
      init_blk <= 1'b0;
    end else begin
      state <= nxt_st;
      if (err_clr)      err <= 1'b0;
      else if (err_set) err <= 1'b1;
      if (rst_req)         init_blk <= 1'b1;
      else if (!init_done) init_blk <= 1'b0;
    end
  end

  // R7: reset request always lands in reset with error cleared
  p_reset_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (state == ST_RESET) && !err);

  // R8: link loss from a reachable level goes to M3
  p_link_m3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_suspend && !rst_req &&
     (state == ST_M0 || state == ST_M1 || state == ST_M2)) |=> (state == ST_M3));

  // R2: reset can only be left towards ready
  p_reset_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |=> (state == ST_RESET || state == ST_READY));

  // R5: error bit is sticky until a reset request
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !rst_req) |=> err);

  // R4: entering M0 needs an M0 request in the prior cycle
  p_m0_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_M0) ##1 (state == ST_M0) |-> $past(req_valid && req_code == ST_M0));
endmodule

// File: rtl/hif_access_gate.sv
module hif_access_gate
  import hif_pwr_pkg::*;
(
  input  pwr_state_e state,
  output logic       reg_access_en,
  output logic       xfer_en
);
  assign reg_access_en = (state != ST_RESET);
  assign xfer_en       = (state == ST_M0);
endmodule

// File: rtl/hif_pwr_ctrl.sv
module hif_pwr_ctrl
  import hif_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_done,
  input  logic            req_valid,
  input  logic [ST_W-1:0] req_code,
  input  logic            link_suspend,
  output logic [ST_W-1:0] state_code,
  output logic            reg_access_en,
  output logic            xfer_en,
  output logic            req_err
);
  pwr_state_e state;

  hif_state_reg u_st (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_done    (init_done),
    .req_valid    (req_valid),
    .req_code     (req_code),
    .link_suspend (link_suspend),
    .state        (state),
    .err          (req_err)
  );

  hif_access_gate u_gate (
    .state         (state),
    .reg_access_en (reg_access_en),
    .xfer_en       (xfer_en)
  );

  assign state_code = state;

  // R3: register access is closed whenever reset is reported
  p_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> !reg_access_en);
endmodule

// File: tb/hif_pwr_ctrl_tb.sv
module hif_pwr_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_done = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_code = 3'd0;
  logic       link_suspend = 1'b0;
  logic [2:0] state_code;
  logic       reg_access_en;
  logic       xfer_en;
  logic       req_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic       err;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  hif_pwr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_valid(req_valid),
    .req_code(req_code), .link_suspend(link_suspend), .state_code(state_code),
    .reg_access_en(reg_access_en), .xfer_en(xfer_en), .req_err(req_err)
  );

  function automatic void compare(exp_t e);
    logic ea, ex;
    ea = (e.st != 3'd0);
    ex = (e.st == 3'd2);
    n_chk++;
    if (state_code !== e.st || req_err !== e.err || reg_access_en !== ea || xfer_en !== ex) begin
      n_fail++;
      $display("FAIL %s: got st=%0d err=%0b acc=%0b xfer=%0b exp st=%0d err=%0b acc=%0b xfer=%0b",
               e.tag, state_code, req_err, reg_access_en, xfer_en, e.st, e.err, ea, ex);
    end
  endfunction

  // monitor: judge one expected item per cycle after the edge settles
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) compare(sb.pop_front());
  end

  task automatic drive(input logic rv, input logic [2:0] rc, input logic ls, input logic id,
                       input logic [2:0] est, input logic eerr, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = rv; req_code = rc; link_suspend = ls; init_done = id;
    e.st = est; e.err = eerr; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    exp_t e0;
    #10;
    e0.st = 3'd0; e0.err = 1'b0; e0.tag = "R1 reset state";
    compare(e0);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 0, 0, 0, 3'd0, 0, "R2 no init stays reset");
    drive(1, 2, 0, 0, 3'd0, 1, "R5 M0 from reset rejected");
    drive(0, 0, 0, 1, 3'd1, 1, "R2 ready after init");
    drive(1, 2, 0, 1, 3'd2, 1, "R4 M0 from ready");
    drive(1, 2, 0, 1, 3'd2, 1, "R5 M0 from M0 rejected");
    drive(1, 0, 0, 1, 3'd0, 0, "R7 reset request");
    drive(0, 0, 0, 1, 3'd0, 0, "R7 ready blocked");
    drive(0, 0, 0, 0, 3'd0, 0, "R7 init low");
    drive(0, 0, 0, 1, 3'd1, 0, "R2 ready again");
    drive(1, 3, 0, 1, 3'd1, 1, "R6 M1 from ready rejected");
    drive(1, 2, 0, 1, 3'd2, 1, "R4 M0 from ready");
    drive(1, 4, 0, 1, 3'd4, 1, "R6 M2 from M0");
    drive(1, 3, 0, 1, 3'd4, 1, "R6 M1 from M2 rejected");
    drive(1, 5, 0, 1, 3'd5, 1, "R6 M3 from M2");
    drive(1, 2, 0, 1, 3'd2, 1, "R4 M0 from M3");
    drive(1, 3, 0, 1, 3'd3, 1, "R6 M1 from M0");
    drive(1, 2, 0, 1, 3'd2, 1, "R4 M0 from M1");
    drive(1, 4, 0, 1, 3'd4, 1, "R6 M2 from M0");
    drive(1, 2, 0, 1, 3'd2, 1, "R4 M0 from M2");
    drive(1, 6, 0, 1, 3'd2, 1, "R6 code 6 rejected");
    drive(1, 0, 0, 1, 3'd0, 0, "R7 reset clears err");
    drive(0, 0, 0, 0, 3'd0, 0, "R7 init low");
    drive(0, 0, 0, 1, 3'd1, 0, "R2 ready");
    drive(1, 1, 0, 1, 3'd1, 1, "R6 code 1 rejected");
    drive(1, 0, 0, 1, 3'd0, 0, "R7 reset from ready");
    drive(0, 0, 0, 0, 3'd0, 0, "R7 init low");
    drive(0, 0, 0, 1, 3'd1, 0, "R2 ready");
    drive(1, 2, 0, 1, 3'd2, 0, "R4 M0");
    drive(1, 3, 1, 1, 3'd5, 0, "R8 link suspend beats M1 request");
    drive(1, 2, 1, 1, 3'd5, 1, "R9 M0 in M3 with link down");
    drive(1, 0, 1, 1, 3'd0, 0, "R10 reset beats link suspend");
    drive(0, 0, 0, 0, 3'd0, 0, "R7 init low");
    drive(0, 0, 0, 1, 3'd1, 0, "R2 ready");
    drive(1, 2, 0, 1, 3'd2, 0, "R4 M0");
    drive(1, 3, 0, 1, 3'd3, 0, "R6 M1 from M0");
    drive(0, 0, 1, 1, 3'd5, 0, "R8 link suspend from M1");
    drive(0, 0, 0, 1, 3'd5, 0, "R8 M3 held");
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule